// File: doc/BRIEF.md
# MOESI Snooping Line-State Controller

This block keeps the coherence state of every line of one cache that sits on a shared snooping bus. Each line is in one of five states: Invalid (I), Shared (S), Exclusive (E), Owned (O) or Modified (M). The Owned state lets a dirty line be shared with other caches. When another cache reads a line that this cache holds dirty, this cache hands the data across directly and keeps ownership. Memory is not updated at that point. The write to memory is deferred until the owner evicts the line. A clean Shared copy never supplies data: reads of clean shared data are served by memory. Sharers do not announce their evictions and no sharer count is kept, so an owner never learns that it has become the only holder.

The processor side presents one request per cycle: a read, a write or an eviction, together with a line index. The controller answers in the same cycle with a hit indication, a bus transaction code, a memory-fill flag or a writeback request. Two bus responses from the other caches are sampled in that same cycle: a shared wire, and an ownership wire raised by a cache that will supply the data. The snoop side presents the transaction another cache placed on the bus, with its line index. The controller answers with the shared signal and an owner-supplies-data strobe. The state change for both sides takes effect at the next rising clock edge.

A configuration input selects how the owner handles its own writes. In invalidate mode it issues an upgrade, which invalidates the other copies, and it goes to Modified. In update mode it broadcasts the new contents and stays Owned.

Top module: `moesi_ctrl`

Named transitions, processor side:

| Start state | Read | Write | Eviction |
|---|---|---|---|
| I | I→E via BusRd when no sharer answers; I→S via BusRd otherwise | I→M via BusRdX | nothing |
| S | hit | S→M via BusUpgr | S→I, silent |
| E | hit | E→M, silent | E→I, silent |
| O | hit | O→M via BusUpgr (invalidate mode); O→O via BusUpd (update mode) | O→I with writeback |
| M | hit | hit | M→I with writeback |

Named transitions, snoop side:

| Start state | Snooped BusRd | Snooped BusRdX | Snooped BusUpgr |
|---|---|---|---|
| M | M→O, supply data | M→I, supply data | M→I |
| O | O→O, supply data | O→I, supply data | O→I |
| E | E→S, shared signal only | E→I | E→I |
| S | stays S, shared signal only | S→I | S→I |

A snooped BusUpd leaves every state unchanged.

## Requirements
- R1: After reset every line is Invalid. A snooped BusRd (snp_op=1) on any line raises neither snp_shared nor snp_supply, and a processor read (cpu_op=1) of any line issues BusRd (bus_op=1). The cpu_op codes are 0 none, 1 read, 2 write, 3 evict.
- R2: A read of an Invalid line issues BusRd with cpu_hit low. fill_from_mem equals the inverse of bus_owner_in. The line enters Exclusive when neither bus_shared_in nor bus_owner_in is high, and Shared otherwise.
- R3: A write to an Invalid line issues BusRdX (bus_op=2) with fill_from_mem equal to the inverse of bus_owner_in, and the line enters Modified. A write to a Shared line issues BusUpgr (bus_op=3) with no fill, and the line enters Modified.
- R4: A read of an S, E, O or M line, and a write to an E or M line, raise cpu_hit with bus_op=0. A write to an Exclusive line moves it to Modified silently.
- R5: A write to an Owned line with cfg_update=0 issues BusUpgr and moves the line to Modified. With cfg_update=1 it issues BusUpd (bus_op=4), keeps the line Owned and leaves cpu_hit low.
- R6: A snooped BusRd on a Modified line raises snp_supply and snp_shared, and the line becomes Owned.
- R7: A snooped BusRd on an Owned line raises snp_supply and snp_shared, and the line stays Owned. On an Exclusive line it raises only snp_shared and the line becomes Shared. On a Shared line it raises only snp_shared. A Shared line never raises snp_supply.
- R8: A snooped BusRdX on an M or O line raises snp_supply, and the line becomes Invalid. A snooped BusRdX on an E or S line, and a snooped BusUpgr (snp_op=3) on any valid line, invalidate the line without snp_supply. A snooped BusUpd (snp_op=4) changes nothing and raises nothing. snp_op values 0 and 5 to 7 mean no snoop.
- R9: Evicting an M or O line raises wb_req and leaves the line Invalid. Evicting an E or S line is silent and leaves the line Invalid. Evicting an Invalid line has no effect.
- R10: A processor request and a snoop on the same index in the same cycle drop cpu_ready. All processor-side outputs then stay low, the snoop is applied, and the processor request leaves the line unchanged.
- R11: A request or snoop on one index never changes the state or the responses of any other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_update | input | 1 | 1: owner writes broadcast an update; 0: owner writes invalidate |
| cpu_op | input | 2 | Processor request code |
| cpu_idx | input | IDX_W | Line index of the processor request |
| cpu_ready | output | 1 | Low when the processor request is dropped by a same-line snoop |
| cpu_hit | output | 1 | Request completed without a bus transaction |
| bus_op | output | 3 | Bus transaction issued for the processor request |
| bus_shared_in | input | 1 | Another cache holds the line (response to own BusRd) |
| bus_owner_in | input | 1 | Another cache will supply the data |
| fill_from_mem | output | 1 | Line data must come from memory |
| wb_req | output | 1 | Write the evicted dirty line back to memory |
| snp_op | input | 3 | Transaction snooped from another cache |
| snp_idx | input | IDX_W | Line index of the snooped transaction |
| snp_shared | output | 1 | This cache holds a valid copy of the snooped line |
| snp_supply | output | 1 | This cache supplies the data for the snooped transaction |

## Verification
A processor request and a snooped transaction can arrive in the same cycle. The pair matters most when both name the same line: the snoop must win, and the request must be dropped without side effects. The bench sweeps every start state against every processor code, every snoop code, both bus response wires and both write modes. In half of the sweep the snoop targets the same index as the request, and in the other half a neighbouring index. The bench judges each cycle against a state model built from the requirements. It then probes the line with a snooped read and a write, so that a wrongly applied request or a missed snoop shows up in the visible responses.

// File: rtl/moesi_pkg.sv
`timescale 1ns/1ps
package moesi_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        CPU_NOP   = 2'd0,
        CPU_RD    = 2'd1,
        CPU_WR    = 2'd2,
        CPU_EVICT = 2'd3
    } cpu_op_e;

    typedef enum logic [2:0] {
        BUS_NONE = 3'd0,
        BUS_RD   = 3'd1,
        BUS_RDX  = 3'd2,
        BUS_UPGR = 3'd3,
        BUS_UPD  = 3'd4
    } bus_op_e;

    typedef struct packed {
        logic [2:0] bus_op;
        logic       hit;
        logic       fill;
        logic       wb;
    } cpu_resp_t;

    typedef struct packed {
        logic shared;
        logic supply;
    } snp_resp_t;

endpackage

// File: rtl/moesi_resp_merge.sv
`timescale 1ns/1ps
module moesi_resp_merge #(
    parameter int N = 8,
    parameter int W = 4
) (
    input  logic [N-1:0][W-1:0] resp_in,
    output logic [W-1:0]        resp_out
);
    // Only the selected line drives non-zero responses; OR them together.
    always_comb begin
        resp_out = '0;
        for (int i = 0; i < N; i++) begin
            resp_out = resp_out | resp_in[i];
        end
    end
endmodule

// File: rtl/moesi_line_fsm.sv
`timescale 1ns/1ps
module moesi_line_fsm
    import moesi_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_update,
    input  logic      cpu_sel,
    input  cpu_op_e   cpu_op,
    input  logic      snp_sel,
    input  logic [2:0] snp_op,
    input  logic      bus_shared_in,
    input  logic      bus_owner_in,
    output cpu_resp_t cpu_resp,
    output snp_resp_t snp_resp
);
    line_st_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_I;
        else        state_q <= state_d;
    end

    // Next state: a snoop on this line takes precedence over the processor
    always_comb begin
        state_d = state_q;
        if (snp_sel) begin
            unique case (state_q)
                ST_M: begin
                    if (snp_op == BUS_RD) state_d = ST_O;
                    else if (snp_op == BUS_RDX || snp_op == BUS_UPGR) state_d = ST_I;
                end
                ST_O: begin
                    if (snp_op == BUS_RDX || snp_op == BUS_UPGR) state_d = ST_I;
                end
                ST_E: begin
                    if (snp_op == BUS_RD) state_d = ST_S;
                    else if (snp_op == BUS_RDX || snp_op == BUS_UPGR) state_d = ST_I;
                end
                ST_S: begin
                    if (snp_op == BUS_RDX || snp_op == BUS_UPGR) state_d = ST_I;
                end
                ST_I: state_d = ST_I;
                default: state_d = ST_I;
            endcase
        end else if (cpu_sel) begin
            unique case (state_q)
                ST_I: begin
                    case (cpu_op)
                        CPU_RD: state_d = (bus_shared_in || bus_owner_in) ? ST_S : ST_E;
                        CPU_WR: state_d = ST_M;
                        default: state_d = ST_I;
                    endcase
                end
                ST_S, ST_E: begin
                    case (cpu_op)
                        CPU_WR:    state_d = ST_M;
                        CPU_EVICT: state_d = ST_I;
                        default:   state_d = state_q;
                    endcase
                end
                ST_O: begin
                    case (cpu_op)
                        CPU_WR:    state_d = cfg_update ? ST_O : ST_M;
                        CPU_EVICT: state_d = ST_I;
                        default:   state_d = ST_O;
                    endcase
                end
                ST_M: begin
                    if (cpu_op == CPU_EVICT) state_d = ST_I;
                end
                default: state_d = ST_I;
            endcase
        end
    end

    // Outputs toward the processor side
    always_comb begin
        cpu_resp = '0;
        if (cpu_sel) begin
            unique case (state_q)
                ST_I: begin
                    if (cpu_op == CPU_RD) begin
                        cpu_resp.bus_op = BUS_RD;
                        cpu_resp.fill   = !bus_owner_in;
                    end else if (cpu_op == CPU_WR) begin
                        cpu_resp.bus_op = BUS_RDX;
                        cpu_resp.fill   = !bus_owner_in;
                    end
                end
                ST_S: begin
                    if (cpu_op == CPU_RD)      cpu_resp.hit    = 1'b1;
                    else if (cpu_op == CPU_WR) cpu_resp.bus_op = BUS_UPGR;
                end
                ST_E, ST_M: begin
                    if (cpu_op == CPU_RD || cpu_op == CPU_WR) cpu_resp.hit = 1'b1;
                    if (cpu_op == CPU_EVICT && state_q == ST_M) cpu_resp.wb = 1'b1;
                end
                ST_O: begin
                    if (cpu_op == CPU_RD)      cpu_resp.hit    = 1'b1;
                    else if (cpu_op == CPU_WR) cpu_resp.bus_op = cfg_update ? BUS_UPD : BUS_UPGR;
                    else if (cpu_op == CPU_EVICT) cpu_resp.wb  = 1'b1;
                end
                default: cpu_resp = '0;
            endcase
        end
    end

    // Outputs toward the snooping bus
    always_comb begin
        snp_resp = '0;
        if (snp_sel) begin
            unique case (state_q)
                ST_M, ST_O: begin
                    snp_resp.supply = (snp_op == BUS_RD) || (snp_op == BUS_RDX);
                    snp_resp.shared = (snp_op == BUS_RD);
                end
                ST_E, ST_S: snp_resp.shared = (snp_op == BUS_RD);
                ST_I:       snp_resp = '0;
                default:    snp_resp = '0;
            endcase
        end
    end

    // R6
    m_to_o_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_M && snp_sel && snp_op == BUS_RD) |=> state_q == ST_O);

    // R9
    wb_to_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp.wb |=> state_q == ST_I);

    // R5
    upd_keeps_o_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_O && cpu_sel && cpu_op == CPU_WR && cfg_update) |=> state_q == ST_O);

    // R7
    s_never_supplies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_S |-> !snp_resp.supply);

    // R4
    e_write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_E && cpu_sel && cpu_op == CPU_WR) |-> cpu_resp.bus_op == BUS_NONE);

endmodule

// File: rtl/moesi_ctrl.sv
`timescale 1ns/1ps
module moesi_ctrl
    import moesi_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_update,
    input  logic [1:0]       cpu_op,
    input  logic [IDX_W-1:0] cpu_idx,
    output logic             cpu_ready,
    output logic             cpu_hit,
    output logic [2:0]       bus_op,
    input  logic             bus_shared_in,
    input  logic             bus_owner_in,
    output logic             fill_from_mem,
    output logic             wb_req,
    input  logic [2:0]       snp_op,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             snp_shared,
    output logic             snp_supply
);
    localparam int CW = $bits(cpu_resp_t);
    localparam int SW = $bits(snp_resp_t);

    logic snp_active, cpu_active, collide;
    logic [NUM_LINES-1:0][CW-1:0] cpu_vec;
    logic [NUM_LINES-1:0][SW-1:0] snp_vec;
    logic [NUM_LINES-1:0]         sup_vec;
    logic [CW-1:0] cpu_merged;
    logic [SW-1:0] snp_merged;
    cpu_resp_t cpu_m;
    snp_resp_t snp_m;

    assign snp_active = (snp_op == BUS_RD) || (snp_op == BUS_RDX) ||
                        (snp_op == BUS_UPGR) || (snp_op == BUS_UPD);
    assign cpu_active = (cpu_op != CPU_NOP);
    assign collide    = snp_active && cpu_active && (cpu_idx == snp_idx);
    assign cpu_ready  = !collide;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        cpu_resp_t cr;
        snp_resp_t sr;
        logic      csel, ssel;
        assign csel = cpu_active && !collide && (cpu_idx == IDX_W'(g));
        assign ssel = snp_active && (snp_idx == IDX_W'(g));

        moesi_line_fsm u_line (
            .clk           (clk),
            .rst_n         (rst_n),
            .cfg_update    (cfg_update),
            .cpu_sel       (csel),
            .cpu_op        (cpu_op_e'(cpu_op)),
            .snp_sel       (ssel),
            .snp_op        (snp_op),
            .bus_shared_in (bus_shared_in),
            .bus_owner_in  (bus_owner_in),
            .cpu_resp      (cr),
            .snp_resp      (sr)
        );

        assign cpu_vec[g] = cr;
        assign snp_vec[g] = sr;
        assign sup_vec[g] = sr.supply;
    end

    moesi_resp_merge #(.N(NUM_LINES), .W(CW)) u_cpu_merge (
        .resp_in  (cpu_vec),
        .resp_out (cpu_merged)
    );

    moesi_resp_merge #(.N(NUM_LINES), .W(SW)) u_snp_merge (
        .resp_in  (snp_vec),
        .resp_out (snp_merged)
    );

    assign cpu_m         = cpu_resp_t'(cpu_merged);
    assign snp_m         = snp_resp_t'(snp_merged);
    assign cpu_hit       = cpu_m.hit;
    assign bus_op        = cpu_m.bus_op;
    assign fill_from_mem = cpu_m.fill;
    assign wb_req        = cpu_m.wb;
    assign snp_shared    = snp_m.shared;
    assign snp_supply    = snp_m.supply;

    // R10
    collide_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |-> (bus_op == 3'd0 && !wb_req && !cpu_hit && !fill_from_mem));

    // R8
    supply_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (snp_op == 3'd1 || snp_op == 3'd2));

    // R11
    one_supplier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sup_vec));

endmodule

// File: tb/sim_moesi_ctrl.sv
`timescale 1ns/1ps
module sim_moesi_ctrl;
    localparam int NL = 4;
    localparam int IW = 2;
    localparam int SI = 0, SS = 1, SE = 2, SO = 3, SM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_update = 1'b0;
    logic [1:0] cpu_op = '0;
    logic [IW-1:0] cpu_idx = '0;
    logic cpu_ready, cpu_hit, fill_from_mem, wb_req, snp_shared, snp_supply;
    logic [2:0] bus_op;
    logic bus_shared_in = 1'b0, bus_owner_in = 1'b0;
    logic [2:0] snp_op = '0;
    logic [IW-1:0] snp_idx = '0;

    int vectors = 0;
    int fails = 0;
    int mst [NL];

    always #4 clk = ~clk;

    moesi_ctrl #(.NUM_LINES(NL)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_update(cfg_update),
        .cpu_op(cpu_op), .cpu_idx(cpu_idx), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
        .bus_op(bus_op), .bus_shared_in(bus_shared_in), .bus_owner_in(bus_owner_in),
        .fill_from_mem(fill_from_mem), .wb_req(wb_req),
        .snp_op(snp_op), .snp_idx(snp_idx), .snp_shared(snp_shared), .snp_supply(snp_supply)
    );

    function automatic string req_tag(int cop, int cs, int sop, int ss, bit col);
        bit sv = (sop >= 1 && sop <= 4);
        if (col) return "R10";
        if (cop != 0 && sv) return "R11";
        if (sv) begin
            if (sop == 1 && ss == SM) return "R6";
            if (sop == 1) return (ss == SI) ? "R1" : "R7";
            return "R8";
        end
        if (cop == 1 && cs == SI) return "R2";
        if (cop == 2 && (cs == SI || cs == SS)) return "R3";
        if (cop == 2 && cs == SO) return "R5";
        if (cop == 3) return "R9";
        if (cop != 0) return "R4";
        return "R11";
    endfunction

    task automatic step(input int cop, input int ci, input int sop, input int si,
                        input int sh, input int own, input int cfg);
        bit col, sv;
        int e_rdy, e_hit, e_bus, e_fill, e_wb, e_shr, e_sup;
        int cs, ss, ns_c, ns_s;
        string tag;
        @(negedge clk);
        cpu_op = 2'(cop); cpu_idx = IW'(ci); snp_op = 3'(sop); snp_idx = IW'(si);
        bus_shared_in = sh[0]; bus_owner_in = own[0]; cfg_update = cfg[0];
        #2;
        sv  = (sop >= 1 && sop <= 4);
        col = (cop != 0) && sv && (ci == si);
        cs = mst[ci]; ss = mst[si]; ns_c = cs; ns_s = ss;
        e_rdy = col ? 0 : 1;
        e_hit = 0; e_bus = 0; e_fill = 0; e_wb = 0; e_shr = 0; e_sup = 0;
        if (sv) begin
            if ((ss == SM || ss == SO) && (sop == 1 || sop == 2)) e_sup = 1;
            if (ss != SI && sop == 1) e_shr = 1;
            if (sop == 1 && ss == SM) ns_s = SO;
            if (sop == 1 && ss == SE) ns_s = SS;
            if ((sop == 2 || sop == 3) && ss != SI) ns_s = SI;
        end
        if (cop != 0 && !col) begin
            if (cop == 1) begin
                if (cs == SI) begin
                    e_bus = 1; e_fill = own ? 0 : 1;
                    ns_c = (sh != 0 || own != 0) ? SS : SE;
                end else e_hit = 1;
            end else if (cop == 2) begin
                if (cs == SI) begin e_bus = 2; e_fill = own ? 0 : 1; ns_c = SM; end
                else if (cs == SS) begin e_bus = 3; ns_c = SM; end
                else if (cs == SO) begin e_bus = cfg ? 4 : 3; ns_c = cfg ? SO : SM; end
                else begin e_hit = 1; ns_c = SM; end
            end else begin
                if (cs == SM || cs == SO) e_wb = 1;
                ns_c = SI;
            end
        end
        tag = req_tag(cop, cs, sop, ss, col);
        vectors++;
        if (cpu_ready !== e_rdy[0] || cpu_hit !== e_hit[0] || bus_op !== 3'(e_bus) ||
            fill_from_mem !== e_fill[0] || wb_req !== e_wb[0] ||
            snp_shared !== e_shr[0] || snp_supply !== e_sup[0]) begin
            fails++;
            $display("FAIL %s cop=%0d idx=%0d st=%0d sop=%0d sidx=%0d st=%0d | got rdy=%0b hit=%0b bus=%0d fill=%0b wb=%0b shr=%0b sup=%0b exp rdy=%0d hit=%0d bus=%0d fill=%0d wb=%0d shr=%0d sup=%0d",
                     tag, cop, ci, cs, sop, si, ss, cpu_ready, cpu_hit, bus_op, fill_from_mem,
                     wb_req, snp_shared, snp_supply, e_rdy, e_hit, e_bus, e_fill, e_wb, e_shr, e_sup);
        end
        if (sv) mst[si] = ns_s;
        if (cop != 0 && !col) mst[ci] = ns_c;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int iter;
        for (int i = 0; i < NL; i++) mst[i] = SI;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state visible through snoops and read misses
        for (int i = 0; i < NL; i++) step(0, 0, 1, i, 0, 0, 0);
        for (int i = 0; i < NL; i++) step(1, i, 0, 0, 0, 0, 0);
        iter = 0;
        for (int s0 = 0; s0 < 5; s0++)
        for (int cop = 0; cop < 4; cop++)
        for (int sop = 0; sop < 6; sop++)
        for (int same = 0; same < 2; same++)
        for (int sh = 0; sh < 2; sh++)
        for (int own = 0; own < 2; own++)
        for (int cfg = 0; cfg < 2; cfg++) begin
            int ln, oth;
            ln  = iter % NL;
            oth = (ln + 1) % NL;
            iter++;
            // R9: clear the line, then bring it to the start state
            step(3, ln, 0, 0, 0, 0, 0);
            if (s0 == SE) step(1, ln, 0, 0, 0, 0, 0);
            if (s0 == SS) step(1, ln, 0, 0, 1, 0, 0);
            if (s0 == SM || s0 == SO) step(2, ln, 0, 0, 0, 0, 0);
            if (s0 == SO) step(0, 0, 1, ln, 0, 0, 0);
            // R10/R11: action, snoop on same or neighbouring line
            step(cop, ln, sop, same ? ln : oth, sh, own, cfg);
            // probes expose the resulting state
            step(0, 0, 1, ln, 0, 0, 0);
            step(2, ln, 0, 0, 0, 0, 0);
            step(0, 0, 1, oth, 0, 0, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule